// File: doc/BRIEF.md
# Frame Writeback Sequencer

This block writes one frame, line by line, into memory. Software programs a base address, a line stride in bytes and the frame size through a small register window, then starts the frame by setting a self-clearing start bit in the control word. While the frame runs, the block takes a valid/ready stream of 32-bit words that are already packed and forwards each one as a write request. Each request carries a byte address, the data word and a 4-bit byte strobe.

The block counts words within a line and lines within the frame. It reports how many lines have been fully written. An abort request ends the frame at once. When the block returns to idle it can raise a level interrupt, which software clears through the control word.

Top module: `fwb_seq`

## Requirements
- R1: After reset the base, stride and size registers and the line counter read 0, the control word reads 0x5440_0000, and `irq`, `mw_valid` and `px_ready` are low.
- R2: The base (offset 0x00), stride (0x04) and size (0x08) registers read back the last value written. In the size word, bits 15:0 are the width in words and bits 31:16 are the height in lines. An unmapped offset reads 0.
- R3: In the control word (offset 0x0C), bits 31:24 always read 0x54 and bits 23:22 always read 0b01, whatever is written. The start bit (bit 0) and the abort bit (bit 14) always read 0. Bit 2 (interrupt enable), bits 19:16 (byte strobe) and bit 21 (power-down) read back as written. Bit 1 reads 1 exactly while a frame runs.
- R4: Writing the control word with bit 0 set while idle, with bit 14 and bit 21 clear and with a nonzero size, sets bit 1 at the next clock edge. The same edge resets the line counter to 0.
- R5: The write for word w of line y goes to base + y*stride + 4*w. It carries the stream word unchanged, and its strobe equals control bits 19:16.
- R6: `mw_valid` is `px_valid` gated by a running frame. `px_ready` is `mw_ready` gated the same way. A word is consumed only in a cycle where both valid and ready are high, and a stalled word keeps its address.
- R7: The line counter (offset 0x10, read-only) goes up by one at the edge that accepts the last word of a line. The edge that accepts the last word of the last line also clears bit 1.
- R8: On every return to idle with control bit 2 set, `irq` rises and stays high until the control word is written with bit 2 = 0. With bit 2 clear, `irq` stays low.
- R9: A control write with bit 14 set during a frame forces `mw_valid` and `px_ready` low in that cycle and clears bit 1 at the next edge. The line counter keeps its value, and no further write is issued.
- R10: A start request written while a frame runs is ignored. The frame continues at the same address, and the line counter is not reset.
- R11: A control write with bit 21 set starts no frame, even with bit 0 set.
- R12: A start request with width 0 or height 0 never sets bit 1. It counts as an immediate return to idle, so `irq` rises if bit 2 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 8 | Register byte offset |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data for csr_addr (combinational) |
| px_valid | input | 1 | Stream word valid |
| px_data | input | 32 | Stream word |
| px_ready | output | 1 | Stream word taken when high with px_valid |
| mw_valid | output | 1 | Memory write request valid |
| mw_ready | input | 1 | Memory accepts the write |
| mw_addr | output | 32 | Byte address of the write |
| mw_data | output | 32 | Write data |
| mw_strb | output | 4 | Byte strobes |
| irq | output | 1 | Idle interrupt, level |

## Verification
Register readback, the write address, data, strobe and the handshake outputs are combinational. They are due in the same cycle as the stimulus and are sampled one nanosecond after the falling edge that applied it. The busy bit, the line counter and `irq` change at the rising edge that takes a control write or a word, so the bench reads them at the following falling edge. The abort case is checked twice: once in the cycle of the write, to show that the request drops, and once after the edge, to show the idle state with the line counter held.

// File: rtl/fwb_pkg.sv
package fwb_pkg;

  localparam int REG_W = 32;
  localparam int DIM_W = 16;

  localparam logic [7:0] OFS_BASE   = 8'h00;
  localparam logic [7:0] OFS_STRIDE = 8'h04;
  localparam logic [7:0] OFS_SIZE   = 8'h08;
  localparam logic [7:0] OFS_CTRL   = 8'h0C;
  localparam logic [7:0] OFS_LINES  = 8'h10;

  localparam int CB_START = 0;
  localparam int CB_IEN   = 2;
  localparam int CB_STOP  = 14;
  localparam int CB_STRB  = 16;
  localparam int CB_SLEEP = 21;

  localparam logic [7:0] ID_HI = 8'h54;
  localparam logic [1:0] ID_LO = 2'b01;

  typedef enum logic {ST_IDLE, ST_RUN} fwb_state_e;

  typedef struct packed {
    logic       start;
    logic       ien;
    logic       stop;
    logic       sleep;
    logic [3:0] strb;
  } ctrl_wr_t;

endpackage

// File: rtl/fwb_regs.sv
module fwb_regs
  import fwb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CSR_AW = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                csr_we,
  input  logic [CSR_AW-1:0]   csr_addr,
  input  logic [REG_W-1:0]    csr_wdata,
  input  logic [REG_W-1:0]    ctrl_word,
  input  logic [DIM_W-1:0]    lines_done,
  output logic                ctrl_we,
  output logic [ADDR_W-1:0]   base_addr,
  output logic [ADDR_W-1:0]   stride,
  output logic [DIM_W-1:0]    width,
  output logic [DIM_W-1:0]    height,
  output logic [REG_W-1:0]    csr_rdata
);

  logic sel_base, sel_stride, sel_size, sel_ctrl, sel_lines;
  logic [ADDR_W-1:0]  base_q, stride_q;
  logic [2*DIM_W-1:0] size_q;

  always_comb begin
    sel_base   = (csr_addr == CSR_AW'(OFS_BASE));
    sel_stride = (csr_addr == CSR_AW'(OFS_STRIDE));
    sel_size   = (csr_addr == CSR_AW'(OFS_SIZE));
    sel_ctrl   = (csr_addr == CSR_AW'(OFS_CTRL));
    sel_lines  = (csr_addr == CSR_AW'(OFS_LINES));
  end

  assign ctrl_we = csr_we & sel_ctrl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= '0;
      stride_q <= '0;
      size_q   <= '0;
    end else begin
      if (csr_we && sel_base)   base_q   <= csr_wdata[ADDR_W-1:0];
      if (csr_we && sel_stride) stride_q <= csr_wdata[ADDR_W-1:0];
      if (csr_we && sel_size)   size_q   <= csr_wdata[2*DIM_W-1:0];
    end
  end

  assign base_addr = base_q;
  assign stride    = stride_q;
  assign width     = size_q[DIM_W-1:0];
  assign height    = size_q[2*DIM_W-1:DIM_W];

  always_comb begin
    csr_rdata = '0;
    if (sel_base)   csr_rdata = REG_W'(base_q);
    if (sel_stride) csr_rdata = REG_W'(stride_q);
    if (sel_size)   csr_rdata = REG_W'(size_q);
    if (sel_ctrl)   csr_rdata = ctrl_word;
    if (sel_lines)  csr_rdata = REG_W'(lines_done);
  end

endmodule

// File: rtl/fwb_ctrl.sv
module fwb_ctrl
  import fwb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_we,
  input  ctrl_wr_t         cw,
  input  logic             frame_done,
  input  logic             dims_zero,
  output logic             busy,
  output logic             start,
  output logic             stop_hit,
  output logic [3:0]       strb,
  output logic             irq,
  output logic [REG_W-1:0] ctrl_word
);

  fwb_state_e state_q, state_d;
  logic       ien_q, ien_d, sleep_q, sleep_d, irq_q, irq_d;
  logic [3:0] strb_q, strb_d;
  logic       go_req, zero_done, idle_evt;

  assign busy      = (state_q == ST_RUN);
  assign go_req    = ctrl_we & cw.start & ~cw.stop & ~cw.sleep & ~busy;
  assign start     = go_req & ~dims_zero;
  assign zero_done = go_req & dims_zero;
  assign stop_hit  = ctrl_we & cw.stop & busy;
  assign idle_evt  = (busy & (stop_hit | frame_done)) | zero_done;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (start) state_d = ST_RUN;
      ST_RUN:  if (stop_hit || frame_done) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
    ien_d   = ctrl_we ? cw.ien   : ien_q;
    sleep_d = ctrl_we ? cw.sleep : sleep_q;
    strb_d  = ctrl_we ? cw.strb  : strb_q;
    irq_d   = ien_d & (irq_q | idle_evt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ien_q   <= 1'b0;
      sleep_q <= 1'b0;
      strb_q  <= 4'h0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ien_q   <= ien_d;
      sleep_q <= sleep_d;
      strb_q  <= strb_d;
      irq_q   <= irq_d;
    end
  end

  assign strb      = strb_q;
  assign irq       = irq_q;
  assign ctrl_word = {ID_HI, ID_LO, sleep_q, 1'b0, strb_q, 13'b0, ien_q, busy, 1'b0};

  a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ien_q);
  a_r9_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
    stop_hit |=> !busy);
  a_r10_go_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ctrl_we && cw.start && !cw.stop && !frame_done) |=> busy);
  a_r11_sleep_blocks_go: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && ctrl_we && cw.sleep) |=> !busy);
  a_r12_zero_size_idle: assert property (@(posedge clk) disable iff (!rst_n)
    zero_done |=> (!busy && (irq == cw_ien_past)));

  logic cw_ien_past;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cw_ien_past <= 1'b0;
    else        cw_ien_past <= cw.ien;
  end

endmodule

// File: rtl/fwb_addr.sv
module fwb_addr
  import fwb_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              accept,
  input  logic              busy,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [ADDR_W-1:0] stride,
  input  logic [DIM_W-1:0]  width,
  input  logic [DIM_W-1:0]  height,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              frame_done,
  output logic [DIM_W-1:0]  lines_done
);

  logic [DIM_W-1:0]  word_q, word_d, line_q, line_d, prog_q, prog_d;
  logic [ADDR_W-1:0] row_q, row_d;
  logic              line_end;

  assign line_end   = accept & (word_q == width - DIM_W'(1));
  assign frame_done = line_end & (line_q == height - DIM_W'(1));

  always_comb begin
    word_d = word_q;
    line_d = line_q;
    row_d  = row_q;
    prog_d = prog_q;
    if (start) begin
      word_d = '0;
      line_d = '0;
      row_d  = base_addr;
      prog_d = '0;
    end else if (accept) begin
      if (line_end) begin
        word_d = '0;
        line_d = line_q + DIM_W'(1);
        row_d  = row_q + stride;
        prog_d = prog_q + DIM_W'(1);
      end else begin
        word_d = word_q + DIM_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      line_q <= '0;
      row_q  <= '0;
      prog_q <= '0;
    end else begin
      word_q <= word_d;
      line_q <= line_d;
      row_q  <= row_d;
      prog_q <= prog_d;
    end
  end

  assign wr_addr    = row_q + ADDR_W'({word_q, 2'b00});
  assign lines_done = prog_q;

  a_r4_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (lines_done == '0 && wr_addr == $past(base_addr)));
  a_r5_word_step: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !line_end) |=> wr_addr == $past(wr_addr) + ADDR_W'(4));
  a_r7_lines_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> lines_done < height);

endmodule

// File: rtl/fwb_seq.sv
module fwb_seq
  import fwb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CSR_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_we,
  input  logic [CSR_AW-1:0] csr_addr,
  input  logic [31:0]       csr_wdata,
  output logic [31:0]       csr_rdata,
  input  logic              px_valid,
  input  logic [31:0]       px_data,
  output logic              px_ready,
  output logic              mw_valid,
  input  logic              mw_ready,
  output logic [ADDR_W-1:0] mw_addr,
  output logic [31:0]       mw_data,
  output logic [3:0]        mw_strb,
  output logic              irq
);

  logic              ctrl_we, busy, start, stop_hit, frame_done, accept, dims_zero;
  logic [ADDR_W-1:0] base_addr, stride;
  logic [DIM_W-1:0]  width, height, lines_done;
  logic [REG_W-1:0]  ctrl_word;
  ctrl_wr_t          cw;

  always_comb begin
    cw.start = csr_wdata[CB_START];
    cw.ien   = csr_wdata[CB_IEN];
    cw.stop  = csr_wdata[CB_STOP];
    cw.sleep = csr_wdata[CB_SLEEP];
    cw.strb  = csr_wdata[CB_STRB +: 4];
  end

  assign dims_zero = (width == '0) | (height == '0);

  fwb_regs #(.ADDR_W(ADDR_W), .CSR_AW(CSR_AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .ctrl_word(ctrl_word), .lines_done(lines_done),
    .ctrl_we(ctrl_we), .base_addr(base_addr), .stride(stride),
    .width(width), .height(height), .csr_rdata(csr_rdata)
  );

  fwb_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .cw(cw),
    .frame_done(frame_done), .dims_zero(dims_zero), .busy(busy),
    .start(start), .stop_hit(stop_hit), .strb(mw_strb), .irq(irq),
    .ctrl_word(ctrl_word)
  );

  fwb_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .start(start), .accept(accept), .busy(busy),
    .base_addr(base_addr), .stride(stride), .width(width), .height(height),
    .wr_addr(mw_addr), .frame_done(frame_done), .lines_done(lines_done)
  );

  assign mw_valid = busy & px_valid & ~stop_hit;
  assign px_ready = busy & mw_ready & ~stop_hit;
  assign accept   = mw_valid & mw_ready;
  assign mw_data  = px_data;

  a_r6_valid_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mw_valid |-> busy);
  a_r6_take_means_write: assert property (@(posedge clk) disable iff (!rst_n)
    (px_valid && px_ready) |-> (mw_valid && mw_ready));
  a_r6_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_valid && !mw_ready && !stop_hit) |=> $stable(mw_addr));

endmodule

// File: tb/sim_fwb_seq.sv
module sim_fwb_seq;

  logic        clk, rst_n, csr_we, px_valid, mw_ready;
  logic [7:0]  csr_addr;
  logic [31:0] csr_wdata, px_data;
  logic [31:0] csr_rdata, mw_addr, mw_data;
  logic [3:0]  mw_strb;
  logic        px_ready, mw_valid, irq;
  int n_chk = 0;
  int n_err = 0;
  logic [31:0] rv;

  fwb_seq u0 (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .px_valid(px_valid),
    .px_data(px_data), .px_ready(px_ready), .mw_valid(mw_valid),
    .mw_ready(mw_ready), .mw_addr(mw_addr), .mw_data(mw_data),
    .mw_strb(mw_strb), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // rows: {offset, write value, expected readback}
  localparam int NV = 8;
  localparam logic [71:0] VEC [NV] = '{
    {8'h00, 32'h0000_1234, 32'h0000_1234},
    {8'h04, 32'h0000_0040, 32'h0000_0040},
    {8'h08, 32'h0002_0003, 32'h0002_0003},
    {8'h0C, 32'hFFFF_FFFE, 32'h546F_0004},
    {8'h0C, 32'h0020_0001, 32'h5460_0000},
    {8'h10, 32'hFFFF_FFFF, 32'h0000_0000},
    {8'h14, 32'h0000_DEAD, 32'h0000_0000},
    {8'h0C, 32'h0000_0000, 32'h5440_0000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    csr_we = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    csr_addr = a;
    #1 v = csr_rdata;
  endtask

  task automatic push(input string tag, input logic [31:0] exp_a, input logic [31:0] d);
    px_valid = 1'b1; px_data = d;
    #1;
    chk({tag, " addr"}, mw_addr, exp_a);
    chk({tag, " data"}, mw_data, d);
    chk({tag, " valid"}, {31'b0, mw_valid}, 32'd1);
    @(negedge clk);
    px_valid = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_err++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0; csr_we = 1'b0; csr_addr = '0; csr_wdata = '0;
    px_valid = 1'b0; px_data = '0; mw_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(8'h00, rv); chk("R1 base", rv, 32'h0);
    rd(8'h08, rv); chk("R1 size", rv, 32'h0);
    rd(8'h0C, rv); chk("R1 ctrl", rv, 32'h5440_0000);
    rd(8'h10, rv); chk("R1 lines", rv, 32'h0);
    px_valid = 1'b1; #1;
    chk("R1 outputs", {29'b0, irq, mw_valid, px_ready}, 32'h0);
    px_valid = 1'b0;

    // register table (R2 R3 R11)
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][71:64], VEC[i][63:32]);
      rd(VEC[i][71:64], rv);
      chk($sformatf("R2/R3/R11 row %0d", i), rv, VEC[i][31:0]);
    end

    // frame with stall: R4 R5 R6 R7 R8
    wr(8'h00, 32'h0000_1000);
    wr(8'h04, 32'h0000_0040);
    wr(8'h08, 32'h0002_0003);
    wr(8'h0C, 32'h000A_0005);
    rd(8'h0C, rv); chk("R4 busy set", rv, 32'h544A_0006);
    for (int i = 0; i < 6; i++) begin
      rd(8'h10, rv); chk("R7 lines mid", rv, 32'(i / 3));
      chk("R8 irq low in frame", {31'b0, irq}, 32'd0);
      if (i == 2) begin
        mw_ready = 1'b0; px_valid = 1'b1; px_data = 32'hBAD0;
        #1;
        chk("R6 stall ready", {31'b0, px_ready}, 32'd0);
        chk("R6 stall valid", {31'b0, mw_valid}, 32'd1);
        @(negedge clk);
        mw_ready = 1'b1;
      end
      #1 chk("R5 strobe", {28'b0, mw_strb}, 32'hA);
      push("R5 word", 32'h1000 + 32'((i / 3) * 32'h40) + 32'(4 * (i % 3)), 32'hA000 + 32'(i));
    end
    rd(8'h0C, rv); chk("R7 idle after last", rv, 32'h544A_0004);
    rd(8'h10, rv); chk("R7 lines final", rv, 32'd2);
    chk("R8 irq raised", {31'b0, irq}, 32'd1);
    px_valid = 1'b1; #1;
    chk("R6 no write idle", {31'b0, mw_valid}, 32'd0);
    px_valid = 1'b0;
    wr(8'h0C, 32'h000A_0000);
    chk("R8 irq ack", {31'b0, irq}, 32'd0);

    // GO while busy: R10, no enable: R8
    wr(8'h00, 32'h0000_3000);
    wr(8'h04, 32'h0000_0010);
    wr(8'h08, 32'h0002_0002);
    wr(8'h0C, 32'h000F_0001);
    push("R10 w0", 32'h3000, 32'h1);
    push("R10 w1", 32'h3004, 32'h2);
    wr(8'h0C, 32'h000F_0001);
    rd(8'h0C, rv); chk("R10 still busy", rv, 32'h544F_0002);
    rd(8'h10, rv); chk("R10 lines kept", rv, 32'd1);
    push("R10 w2", 32'h3010, 32'h3);
    push("R10 w3", 32'h3014, 32'h4);
    rd(8'h0C, rv); chk("R10 done", rv, 32'h544F_0000);
    chk("R8 no irq when disabled", {31'b0, irq}, 32'd0);

    // abort: R9
    wr(8'h00, 32'h0000_2000);
    wr(8'h04, 32'h0000_0020);
    wr(8'h08, 32'h0002_0004);
    wr(8'h0C, 32'h000F_0005);
    for (int i = 0; i < 5; i++)
      push("R9 pre", 32'h2000 + 32'((i / 4) * 32'h20) + 32'(4 * (i % 4)), 32'h77 + 32'(i));
    px_valid = 1'b1;
    csr_we = 1'b1; csr_addr = 8'h0C; csr_wdata = 32'h0000_4000;
    #1;
    chk("R9 write dropped", {30'b0, mw_valid, px_ready}, 32'd0);
    @(negedge clk);
    csr_we = 1'b0;
    #1 chk("R9 no write after", {31'b0, mw_valid}, 32'd0);
    px_valid = 1'b0;
    rd(8'h0C, rv); chk("R9 idle", rv, 32'h5440_0000);
    rd(8'h10, rv); chk("R9 lines held", rv, 32'd1);
    chk("R9 irq off", {31'b0, irq}, 32'd0);

    // zero size: R12
    wr(8'h08, 32'h0000_0005);
    wr(8'h0C, 32'h000F_0005);
    rd(8'h0C, rv); chk("R12 height 0 not busy", rv, 32'h544F_0004);
    chk("R12 irq", {31'b0, irq}, 32'd1);
    wr(8'h0C, 32'h0000_0000);
    wr(8'h08, 32'h0003_0000);
    wr(8'h0C, 32'h0000_0001);
    px_valid = 1'b1; #1;
    chk("R12 width 0 no write", {31'b0, mw_valid}, 32'd0);
    px_valid = 1'b0;
    rd(8'h0C, rv); chk("R12 width 0 not busy", rv, 32'h5440_0000);

    // sleep with valid size: R11
    wr(8'h08, 32'h0001_0001);
    wr(8'h0C, 32'h0020_0001);
    rd(8'h0C, rv); chk("R11 sleep blocks go", rv, 32'h5460_0000);

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule